// File: doc/BRIEF.md
# Cascadable Configuration Memory Readout

This block is the read side of a configuration store that streams a stored bitstream to a device being configured. The configuring device supplies the clock. Two active-low controls gate the stream. A chip enable selects this unit in a chain. An output-enable/reset line rewinds the stream to its start. The stored bytes come out either one bit per clock, most significant bit first, on bit 0 of the data output, or one byte per clock on all eight data bits. A mode input chooses between the two forms.

Several units can be chained. Each unit's chain-enable output drives the chip enable of the next unit. When a unit has delivered its last bit or byte, its address freezes, it stops driving data, and it pulls its chain-enable output low so that the next unit takes over. The array is a behavioural memory, and a simple write port fills it. The data pads are modelled by a drive flag: while the flag is low, the data output reads zero.

Top module: `cfg_readout`

## Requirements
- R1: While `rst` is high at a clock edge, the block is cleared. After that edge `data_drive` is 0, `chain_en_n` is 1 and `data_out` is 0.
- R2: Serial mode is selected by `par_mode` = 0. The first edge with `chip_en_n` low and `out_en_rst_n` high presents bit 7 of byte 0 on `data_out[0]` and raises `data_drive`. Each later enabled edge presents the next lower bit, then bit 7 of the next byte. `data_out[7:1]` stays 0.
- R3: Parallel mode is selected by `par_mode` = 1. The first enabled edge presents byte 0 on `data_out[7:0]`. Each later enabled edge presents the byte at the next address.
- R4: An edge with `out_en_rst_n` low rewinds the stream to address 0. After that edge `data_drive` is 0 and `chain_en_n` is 1. The next enabled edge presents the first item again.
- R5: An edge with `chip_en_n` high puts the block in standby, whatever the level of `out_en_rst_n`. The stream rewinds, `data_drive` is 0 and `chain_en_n` is 1.
- R6: The terminal position is DEPTH*8-1 bits in serial mode and DEPTH-1 bytes in parallel mode. The enabled edge that follows the terminal item drops `data_drive` and `chain_en_n` in the same cycle.
- R7: Past the terminal position, further enabled edges change nothing: `data_drive` stays 0 and `chain_en_n` stays 0.
- R8: `chain_en_n` is low only while the block is enabled and past its terminal position. After an edge with `out_en_rst_n` low, `chain_en_n` is 1 and stays 1 until a new run passes the terminal position.
- R9: While `data_drive` is 0, `data_out` is 0. This models the floating data output.
- R10: An edge with `load_en` high writes `load_byte` into address `load_addr`. Later readout returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_n | input | 1 | Chain select, active low; high means standby |
| out_en_rst_n | input | 1 | Output enable, active high; low rewinds the stream |
| par_mode | input | 1 | 0 = serial bit stream, 1 = parallel byte stream |
| load_en | input | 1 | Write strobe for the memory preload port |
| load_addr | input | AW | Preload address, AW = clog2(DEPTH) |
| load_byte | input | 8 | Preload data byte |
| data_out | output | 8 | Stream data; bit 0 only in serial mode |
| data_drive | output | 1 | Registered flag: data output is driven |
| chain_en_n | output | 1 | Chain-enable output to the next unit, active low |

## Verification
The hardest point to reach is the handoff at the end of a serial run. The bench must clock all DEPTH*8 bit positions without a break, and only then can it see `data_drive` fall and `chain_en_n` go low on the same edge. The bench preloads a computed byte pattern and walks the full serial and parallel streams, checking every item against that pattern. It then holds the block in the frozen state for several edges. It also pulls `out_en_rst_n` low while `chain_en_n` is low, to show that the chain output returns high and stays high until the stream restarts from address 0.

// File: rtl/cfg_readout_pkg.sv
package cfg_readout_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_SEL_W = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        FMT_SERIAL   = 1'b0,
        FMT_PARALLEL = 1'b1
    } fmt_e;

    // Bit select 0 picks the most significant bit of the byte.
    function automatic logic pick_msb_first(input byte_t b, input logic [BIT_SEL_W-1:0] sel);
        return b[BYTE_W-1-int'(sel)];
    endfunction

    function automatic byte_t shape_output(input byte_t b, input logic [BIT_SEL_W-1:0] sel,
                                           input fmt_e fmt, input logic drive);
        byte_t r;
        r = '0;
        if (drive) begin
            if (fmt == FMT_PARALLEL) r = b;
            else                     r[0] = pick_msb_first(b, sel);
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_readout_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/cfg_pos_counter.sv
module cfg_pos_counter
    import cfg_readout_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  fmt_e                 fmt,
    output logic [AW-1:0]        byte_addr,
    output logic [BIT_SEL_W-1:0] bit_sel,
    output logic                 active,
    output logic                 done
);

    localparam logic [AW-1:0]        LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [BIT_SEL_W-1:0] LAST_BIT  = '1;
    localparam int                   POS_W     = AW + BIT_SEL_W;

    logic at_tc;

    always_comb begin
        at_tc = (byte_addr == LAST_ADDR) &&
                ((fmt == FMT_PARALLEL) || (bit_sel == LAST_BIT));
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            byte_addr <= '0;
            bit_sel   <= '0;
            active    <= 1'b0;
            done      <= 1'b0;
        end else if (!active) begin
            active <= 1'b1;
        end else if (!done) begin
            if (at_tc) begin
                done <= 1'b1;
            end else if (fmt == FMT_PARALLEL) begin
                byte_addr <= byte_addr + AW'(1);
                bit_sel   <= '0;
            end else begin
                {byte_addr, bit_sel} <= {byte_addr, bit_sel} + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/cfg_out_fmt.sv
module cfg_out_fmt
    import cfg_readout_pkg::*;
(
    input  byte_t                rd_byte,
    input  logic [BIT_SEL_W-1:0] bit_sel,
    input  fmt_e                 fmt,
    input  logic                 active,
    input  logic                 done,
    output byte_t                data_out,
    output logic                 data_drive,
    output logic                 chain_en_n
);

    always_comb begin
        data_drive = active && !done;
        chain_en_n = !done;
        data_out   = shape_output(rd_byte, bit_sel, fmt, data_drive);
    end

endmodule

// File: rtl/cfg_readout.sv
module cfg_readout
    import cfg_readout_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_en_n,
    input  logic          out_en_rst_n,
    input  logic          par_mode,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [7:0]    load_byte,
    output logic [7:0]    data_out,
    output logic          data_drive,
    output logic          chain_en_n
);

    fmt_e                 fmt;
    logic                 run_en;
    logic [AW-1:0]        byte_addr;
    logic [BIT_SEL_W-1:0] bit_sel;
    logic                 active;
    logic                 done;
    byte_t                rd_byte;

    assign fmt    = par_mode ? FMT_PARALLEL : FMT_SERIAL;
    assign run_en = !chip_en_n && out_en_rst_n;

    cfg_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_byte),
        .rd_addr (byte_addr),
        .rd_data (rd_byte)
    );

    cfg_pos_counter #(.DEPTH(DEPTH), .AW(AW)) i_pos (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .fmt       (fmt),
        .byte_addr (byte_addr),
        .bit_sel   (bit_sel),
        .active    (active),
        .done      (done)
    );

    cfg_out_fmt i_fmt (
        .rd_byte    (rd_byte),
        .bit_sel    (bit_sel),
        .fmt        (fmt),
        .active     (active),
        .done       (done),
        .data_out   (data_out),
        .data_drive (data_drive),
        .chain_en_n (chain_en_n)
    );

endmodule

// File: rtl/cfg_readout_chk.sv
module cfg_readout_chk (
    input logic       clk,
    input logic       rst,
    input logic       chip_en_n,
    input logic       out_en_rst_n,
    input logic [7:0] data_out,
    input logic       data_drive,
    input logic       chain_en_n
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!data_drive && chain_en_n));

    assert_rewind_R4: assert property (@(posedge clk) disable iff (rst)
        !out_en_rst_n |=> (!data_drive && chain_en_n));

    assert_standby_R5: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |=> (!data_drive && chain_en_n));

    assert_handoff_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(chain_en_n) |-> $fell(data_drive));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!chain_en_n && !chip_en_n && out_en_rst_n) |=> (!chain_en_n && !data_drive));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(data_drive && !chain_en_n));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !data_drive |-> (data_out == 8'h00));

endmodule

bind cfg_readout cfg_readout_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .chip_en_n    (chip_en_n),
    .out_en_rst_n (out_en_rst_n),
    .data_out     (data_out),
    .data_drive   (data_drive),
    .chain_en_n   (chain_en_n)
);

// File: tb/test_cfg_readout.sv
module test_cfg_readout;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          out_en_rst_n = 1'b0;
    logic          par_mode = 1'b0;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0]    load_byte = '0;
    logic [7:0]    data_out;
    logic          data_drive;
    logic          chain_en_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_readout #(.DEPTH(DEPTH)) i_cfg_readout (
        .clk          (clk),
        .rst          (rst),
        .chip_en_n    (chip_en_n),
        .out_en_rst_n (out_en_rst_n),
        .par_mode     (par_mode),
        .load_en      (load_en),
        .load_addr    (load_addr),
        .load_byte    (load_byte),
        .data_out     (data_out),
        .data_drive   (data_drive),
        .chain_en_n   (chain_en_n)
    );

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 5) ^ (i << 4));
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req, input logic exp_chain);
        chk(req, {31'd0, data_drive}, 32'd0);
        chk(req, {31'd0, chain_en_n}, {31'd0, exp_chain});
        chk(req, {24'd0, data_out}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        chk_idle("R1 reset", 1'b1);
        rst = 1'b0;
        step();
        chk_idle("R1 after release", 1'b1);
    endtask

    task automatic t_load();
        for (int i = 0; i < DEPTH; i++) begin
            load_en   = 1'b1;
            load_addr = AW'(i);
            load_byte = pattern(i);
            step();
        end
        load_en = 1'b0;
    endtask

    task automatic t_serial_stream();
        par_mode = 1'b0;
        chip_en_n = 1'b0;
        out_en_rst_n = 1'b1;
        for (int p = 0; p < DEPTH * 8; p++) begin
            logic [7:0] b;
            step();
            b = pattern(p / 8);
            chk("R2 serial bit", {23'd0, data_drive, data_out}, {23'd0, 1'b1, 7'd0, b[7 - (p % 8)]});
            chk("R8 chain high while streaming", {31'd0, chain_en_n}, 32'd1);
        end
        step();
        chk_idle("R6 serial handoff", 1'b0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk_idle("R7 serial frozen", 1'b0);
        end
        chip_en_n = 1'b1;
        step();
        chk_idle("R5 standby after run", 1'b1);
    endtask

    task automatic t_parallel_freeze();
        par_mode = 1'b1;
        chip_en_n = 1'b0;
        out_en_rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            step();
            chk("R3 parallel byte", {23'd0, data_drive, data_out}, {23'd0, 1'b1, pattern(a)});
            chk("R10 loaded byte read back", {24'd0, data_out}, {24'd0, pattern(a)});
        end
        step();
        chk_idle("R6 parallel handoff", 1'b0);
        for (int k = 0; k < 4; k++) begin
            step();
            chk_idle("R7 parallel frozen", 1'b0);
        end
        out_en_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk_idle("R8 chain released by rewind", 1'b1);
        end
        out_en_rst_n = 1'b1;
        step();
        chk("R8 restart byte 0", {23'd0, data_drive, data_out}, {23'd0, 1'b1, pattern(0)});
        chk("R8 chain high on restart", {31'd0, chain_en_n}, 32'd1);
    endtask

    task automatic t_rewind_midstream();
        par_mode = 1'b1;
        chip_en_n = 1'b1;
        step();
        chip_en_n = 1'b0;
        out_en_rst_n = 1'b1;
        for (int a = 0; a < 5; a++) step();
        chk("R3 byte 4 before rewind", {24'd0, data_out}, {24'd0, pattern(4)});
        out_en_rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            step();
            chk_idle("R4 rewind held", 1'b1);
            chk_idle("R9 data zero while undriven", 1'b1);
        end
        out_en_rst_n = 1'b1;
        step();
        chk("R4 resume byte 0", {23'd0, data_drive, data_out}, {23'd0, 1'b1, pattern(0)});
        step();
        chk("R4 resume byte 1", {24'd0, data_out}, {24'd0, pattern(1)});
    endtask

    task automatic t_standby_midstream();
        par_mode = 1'b0;
        chip_en_n = 1'b1;
        step();
        chip_en_n = 1'b0;
        out_en_rst_n = 1'b1;
        for (int p = 0; p < 10; p++) step();
        chk("R2 serial bit 9", {24'd0, data_out}, {31'd0, pattern(1)[6]});
        chip_en_n = 1'b1;
        step();
        chk_idle("R5 standby with enable high", 1'b1);
        out_en_rst_n = 1'b0;
        step();
        chk_idle("R5 standby with enable low", 1'b1);
        out_en_rst_n = 1'b1;
        chip_en_n = 1'b0;
        step();
        chk("R5 resume bit 7 of byte 0", {23'd0, data_drive, data_out}, {23'd0, 1'b1, 7'd0, pattern(0)[7]});
    endtask

    task automatic t_reload();
        chip_en_n = 1'b1;
        load_en = 1'b1;
        load_addr = AW'(0);
        load_byte = 8'hA5;
        step();
        load_en = 1'b0;
        par_mode = 1'b1;
        chip_en_n = 1'b0;
        out_en_rst_n = 1'b1;
        step();
        chk("R10 rewritten byte", {24'd0, data_out}, 32'h0000_00A5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_serial_stream();
        t_parallel_freeze();
        t_rewind_midstream();
        t_standby_midstream();
        t_reload();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule